// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter

This block turns stereo audio samples into a serial bit stream with a bit clock and a word-select (frame) signal. Software or a data mover writes samples into a single holding register. The block fetches a sample from that register at the start of each channel slot and shifts it out most significant bit first. The bit stream can use standard I2S timing, where the data lags the word-select edge by one bit, or left-justified timing, where the data starts on that edge.

The block can generate the bit clock and word select itself, dividing the system clock by a parameter. It can also follow an external bit clock and word select. A set of configuration inputs selects the sample length, the slot width for the mid-length samples, mono duplication and packed two-channel writes. These inputs also select what is sent when a sample is missing. A missing sample is reported per channel on a one-cycle underrun output.

Top module: `i2s_tx`

## Requirements
- R1: A pulse on `cmd_en` sets `tx_enabled` and a pulse on `cmd_dis` clears it, with `cmd_dis` winning when both are high. While disabled, `bclk_o`, `ws_o` and `sd_o` are low and the holding register is emptied.
- R2: `tx_ready` is high exactly when the block is enabled and the holding register is empty. A write (`wr_valid` high) is taken only while `tx_ready` is high. Writes while disabled or while the register is full are ignored.
- R3: When `cfg_master`=1, `bclk_o` has a period of 2*HALF_DIV clock cycles. `ws_o` is low for the left slot and high for the right slot. `ws_o` and `sd_o` change only in the cycle where `bclk_o` falls, and the first falling edge after enable starts a left slot.
- R4: `cfg_len` sets the sample length and slot width. Code 0 gives 32 bits in a 32-bit slot. Codes 4 and 5 give 16 bits in a 16-bit slot. Codes 6 and 7 give 8 bits in an 8-bit slot. Codes 1, 2 and 3 give 24, 20 and 18 bits, in a 24-bit slot when `cfg_slot24`=1 and a 32-bit slot otherwise. Bits after the sample in a slot are zero.
- R5: A sample is the low bits of the written word and is sent MSB first. With `cfg_lj`=0 the MSB appears one bit clock after the word-select change. With `cfg_lj`=1 it appears on the same bit clock as that change.
- R6: With `cfg_mono`=1, each write carries one sample that is sent in the left slot and again in the right slot.
- R7: Codes 5 and 7 of `cfg_len` are packed modes. One 32-bit write carries both channels: the left sample in bits [15:0] and the right in [31:16] for code 5, and the left in [7:0] and the right in [15:8] for code 7.
- R8: If the holding register is empty when a slot needs a sample, the block sends a filler. The filler is zero when `cfg_repeat`=0, or that channel's previous sample when `cfg_repeat`=1. `urun_ch` pulses for one cycle: bit 0 for the left slot, bit 1 for the right slot, and both bits when a packed-mode pair is missing.
- R9: When `cfg_master`=0, the block shifts data on falling edges of `bclk_i`. Each change of `ws_i` seen on a rising edge realigns the slot position, with `ws_i` low meaning the left slot. `bclk_o` and `ws_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate bit clock and word select, 0 = follow external ones |
| cfg_lj | input | 1 | 0 = I2S timing, 1 = left-justified timing |
| cfg_len | input | 3 | Sample length and packing code |
| cfg_slot24 | input | 1 | 24-bit slot for 18/20/24-bit samples |
| cfg_mono | input | 1 | Send the left sample in both slots |
| cfg_repeat | input | 1 | Underrun filler: 0 = zero, 1 = previous sample |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse |
| tx_enabled | output | 1 | Transmitter enabled status |
| wr_valid | input | 1 | Holding register write strobe |
| wr_data | input | 32 | Holding register write data |
| tx_ready | output | 1 | Holding register can accept a write |
| bclk_i | input | 1 | External bit clock (follower mode) |
| ws_i | input | 1 | External word select (follower mode) |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Generated word select |
| sd_o | output | 1 | Serial data |
| urun_ch | output | 2 | Per-channel underrun pulse |

## Verification
The checker watches the cycle-level rules on every cycle. It checks that ready and underrun never appear while disabled, that a disable command takes effect on the next cycle, that the outputs are quiet once disabled, and that in generator mode the word select and data only move together with a falling bit clock. The bit-level content of the stream can only be shown by the bench's scenarios, which decode the captured stream. That content covers MSB-first order, the one-bit I2S lag, slot widths per length code, mono and packed layouts, zero or repeated fillers and which channel underran. Realignment to an external word select and the dropping of writes that arrive while not ready are also shown only by the bench.

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int HALF_DIV = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_lj,
  input  logic [2:0]    cfg_len,
  input  logic          cfg_slot24,
  input  logic          cfg_mono,
  input  logic          cfg_repeat,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  output logic          tx_enabled,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          tx_ready,
  input  logic          bclk_i,
  input  logic          ws_i,
  output logic          bclk_o,
  output logic          ws_o,
  output logic          sd_o,
  output logic [1:0]    urun_ch
);
  localparam int PW = $clog2(2 * DW);
  localparam int CW = $clog2(HALF_DIV) + 1;
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;

  logic            en, hold_full, bclk_q, ws_q, sd_q, prev_lj, ws_seen;
  logic [CW-1:0]   div_cnt;
  logic [PW-1:0]   pos, pos_nx, pos_last, dl, sw, shamt;
  logic [PW:0]     flen;
  logic [DW-1:0]   hold, sh, last_l, last_r, pend, pend_nx, smp, lo_half, hi_half;
  logic [2:0]      bsync;
  logic [1:0]      wsync, ur, urun_q;
  logic            tick, b_rise, b_fall, l_start, r_start, take, compact, lj_bit;

  always_comb begin
    case (cfg_len)
      3'd0:       begin dl = PW'(32); sw = PW'(32); end
      3'd1:       begin dl = PW'(24); sw = cfg_slot24 ? PW'(24) : PW'(32); end
      3'd2:       begin dl = PW'(20); sw = cfg_slot24 ? PW'(24) : PW'(32); end
      3'd3:       begin dl = PW'(18); sw = cfg_slot24 ? PW'(24) : PW'(32); end
      3'd4, 3'd5: begin dl = PW'(16); sw = PW'(16); end
      default:    begin dl = PW'(8);  sw = PW'(8);  end
    endcase
  end

  assign compact  = (cfg_len == 3'd5) || (cfg_len == 3'd7);
  assign shamt    = PW'(DW) - dl;
  assign flen     = {1'b0, sw} << 1;
  assign pos_last = PW'(flen - 1'b1);
  assign pos_nx   = (pos >= pos_last) ? '0 : pos + 1'b1;

  assign tick    = div_cnt == CW'(HALF_DIV - 1);
  assign b_rise  = en & (cfg_master ? (tick & ~bclk_q) : (bsync[1] & ~bsync[2]));
  assign b_fall  = en & (cfg_master ? (tick & bclk_q) : (~bsync[1] & bsync[2]));
  assign l_start = b_fall & (pos_nx == '0);
  assign r_start = b_fall & (pos_nx == sw);

  assign lo_half = (cfg_len == 3'd7) ? {{(DW-BW){1'b0}}, hold[BW-1:0]}
                                     : {{(DW-HW){1'b0}}, hold[HW-1:0]};
  assign hi_half = (cfg_len == 3'd7) ? {{(DW-BW){1'b0}}, hold[2*BW-1:BW]}
                                     : {{(DW-HW){1'b0}}, hold[DW-1:HW]};

  always_comb begin
    take    = 1'b0;
    ur      = 2'b00;
    smp     = '0;
    pend_nx = pend;
    if (l_start) begin
      if (hold_full) begin
        take = 1'b1;
        if (compact) begin
          smp     = lo_half << shamt;
          pend_nx = hi_half << shamt;
        end else begin
          smp = hold << shamt;
        end
      end else begin
        ur      = compact ? 2'b11 : 2'b01;
        smp     = cfg_repeat ? last_l : '0;
        pend_nx = cfg_repeat ? last_r : '0;
      end
    end else if (r_start) begin
      if (cfg_mono) begin
        smp = last_l;
      end else if (compact) begin
        smp = pend;
      end else if (hold_full) begin
        take = 1'b1;
        smp  = hold << shamt;
      end else begin
        ur  = 2'b10;
        smp = cfg_repeat ? last_r : '0;
      end
    end
  end

  assign lj_bit = (l_start | r_start) ? smp[DW-1] : sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; hold_full <= 1'b0; hold <= '0;
      bclk_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0; prev_lj <= 1'b0; ws_seen <= 1'b0;
      div_cnt <= '0; pos <= '1; sh <= '0;
      last_l <= '0; last_r <= '0; pend <= '0;
      bsync <= '0; wsync <= '0; urun_q <= '0;
    end else begin
      bsync  <= {bsync[1:0], bclk_i};
      wsync  <= {wsync[0], ws_i};
      en     <= cmd_dis ? 1'b0 : (cmd_en ? 1'b1 : en);
      urun_q <= ur;
      if (!en) begin
        hold_full <= 1'b0; div_cnt <= '0; bclk_q <= 1'b0;
        ws_q <= 1'b0; sd_q <= 1'b0; prev_lj <= 1'b0; sh <= '0;
        pos <= '1; ws_seen <= 1'b0;
      end else begin
        if (wr_valid && tx_ready) begin
          hold      <= wr_data;
          hold_full <= 1'b1;
        end else if (take) begin
          hold_full <= 1'b0;
        end
        if (cfg_master) begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) bclk_q <= ~bclk_q;
        end
        if (b_rise && !cfg_master) begin
          ws_seen <= wsync[1];
          if (wsync[1] != ws_seen) pos <= wsync[1] ? sw : '0;
        end
        if (b_fall) begin
          pos     <= pos_nx;
          ws_q    <= pos_nx >= sw;
          sd_q    <= cfg_lj ? lj_bit : prev_lj;
          prev_lj <= lj_bit;
          sh      <= (l_start | r_start) ? (smp << 1) : (sh << 1);
          if (l_start) begin
            last_l <= smp;
            pend   <= pend_nx;
          end
          if (r_start) last_r <= smp;
        end
      end
    end
  end

  assign tx_enabled = en;
  assign tx_ready   = en & ~hold_full;
  assign bclk_o     = bclk_q;
  assign ws_o       = cfg_master & ws_q;
  assign sd_o       = sd_q;
  assign urun_ch    = urun_q;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic       cmd_dis,
  input logic       tx_enabled,
  input logic       tx_ready,
  input logic       bclk_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic [1:0] urun_ch
);
  // R2
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_enabled);

  // R8
  urun_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_ch != 2'b00) |-> tx_enabled);

  // R1
  dis_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !tx_enabled);

  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enabled && !$past(tx_enabled)) |-> (!bclk_o && !ws_o && !sd_o));

  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enabled && $past(tx_enabled) && cfg_master && (ws_o != $past(ws_o))) |-> $fell(bclk_o));

  // R3
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enabled && $past(tx_enabled) && cfg_master && (sd_o != $past(sd_o))) |-> $fell(bclk_o));
endmodule

bind i2s_tx i2s_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cmd_dis(cmd_dis),
  .tx_enabled(tx_enabled), .tx_ready(tx_ready), .bclk_o(bclk_o),
  .ws_o(ws_o), .sd_o(sd_o), .urun_ch(urun_ch)
);

// File: tb/i2s_tx_bench.sv
`timescale 1ns/1ps
module i2s_tx_bench;
  localparam int HALF  = 4;
  localparam int SHALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_lj = 1'b0, cfg_slot24 = 1'b0, cfg_mono = 1'b0, cfg_repeat = 1'b0;
  logic [2:0] cfg_len = 3'd0;
  logic cmd_en = 1'b0, cmd_dis = 1'b0, wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic bclk_i = 1'b0, ws_i = 1'b0;
  logic tx_enabled, tx_ready, bclk_o, ws_o, sd_o;
  logic [1:0] urun_ch;

  i2s_tx #(.HALF_DIV(HALF)) u_i2s_tx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lj(cfg_lj), .cfg_len(cfg_len),
    .cfg_slot24(cfg_slot24), .cfg_mono(cfg_mono), .cfg_repeat(cfg_repeat),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .tx_enabled(tx_enabled),
    .wr_valid(wr_valid), .wr_data(wr_data), .tx_ready(tx_ready),
    .bclk_i(bclk_i), .ws_i(ws_i), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .urun_ch(urun_ch));

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  // follower-mode clock source
  bit sl_run = 0;
  int sl_sw = 16, sl_cnt = 0, sl_pos = 0;
  always @(posedge clk) begin
    if (!sl_run) begin
      bclk_i <= 1'b0; ws_i <= 1'b0; sl_cnt = 0; sl_pos = 2 * sl_sw - 1;
    end else begin
      sl_cnt++;
      if (sl_cnt == SHALF) begin
        sl_cnt = 0;
        if (!bclk_i) bclk_i <= 1'b1;
        else begin
          bclk_i <= 1'b0;
          sl_pos = (sl_pos == 2 * sl_sw - 1) ? 0 : sl_pos + 1;
          ws_i <= (sl_pos >= sl_sw);
        end
      end
    end
  end

  // stream capture
  bit cap_on = 0, seen_fall = 0, pb = 0, feed_done = 0;
  int nb = 0, cyc = 0, last_rise = -1, per = 0, n_ur = 0, early = 0;
  logic [1:0] first_ur = 2'b00;
  bit bsd[4096];
  bit bws[4096];
  wire abclk = cfg_master ? bclk_o : bclk_i;
  wire aws   = cfg_master ? ws_o : ws_i;
  always @(negedge clk) begin
    cyc++;
    if (cap_on) begin
      if (pb && !abclk) seen_fall = 1;
      if (!pb && abclk) begin
        if (last_rise >= 0) per = cyc - last_rise;
        last_rise = cyc;
        if (seen_fall && nb < 4096) begin bsd[nb] = sd_o; bws[nb] = aws; nb++; end
      end
      if (urun_ch != 2'b00) begin
        if (n_ur == 0) first_ur = urun_ch;
        n_ur++;
        if (!feed_done) early++;
      end
    end
    pb = abclk;
  end

  function automatic logic [31:0] msk(input logic [31:0] w, input int dl);
    return (dl == 32) ? w : (w & ((32'd1 << dl) - 1));
  endfunction

  function automatic int len_of(input logic [2:0] c);
    case (c) 3'd0: return 32; 3'd1: return 24; 3'd2: return 20; 3'd3: return 18;
      3'd4, 3'd5: return 16; default: return 8; endcase
  endfunction

  logic [31:0] exp_w[64];
  logic [31:0] dw[256];
  bit          dch[256];

  task automatic run(input bit m, input bit lj, input logic [2:0] len, input bit s24,
                     input bit mono, input bit rep, input int nwr, input bit junk,
                     input bit pre, input string tag);
    int dl, sw, nexp, ndata, nwd, off, prev_start, nslot, pp;
    bit comp;
    logic [31:0] w, acc;
    dl   = len_of(len);
    sw   = (len >= 3'd1 && len <= 3'd3) ? (s24 ? 24 : 32) : dl;
    comp = (len == 3'd5) || (len == 3'd7);
    @(negedge clk);
    cfg_master = m; cfg_lj = lj; cfg_len = len; cfg_slot24 = s24;
    cfg_mono = mono; cfg_repeat = rep; sl_sw = sw;
    nb = 0; seen_fall = 0; n_ur = 0; early = 0; first_ur = 2'b00; last_rise = -1; per = 0;
    feed_done = (nwr == 0);
    if (pre) begin
      wr_valid = 1'b1; wr_data = 32'h0000_ABCD;
      @(negedge clk);
      chk(tx_ready == 1'b0, "R2", "ready while disabled", tx_ready, 0);
      wr_valid = 1'b0;
    end
    ndata = 0;
    for (int k = 0; k < nwr; k++) begin
      w = (32'h9E37_79B9 * (k + 1)) ^ {24'd0, len, 5'd3};
      if (mono) begin exp_w[ndata] = msk(w, dl); exp_w[ndata+1] = msk(w, dl); end
      else if (comp && len == 3'd5) begin exp_w[ndata] = {16'd0, w[15:0]}; exp_w[ndata+1] = {16'd0, w[31:16]}; end
      else if (comp) begin exp_w[ndata] = {24'd0, w[7:0]}; exp_w[ndata+1] = {24'd0, w[15:8]}; end
      if (mono || comp) ndata += 2;
      else begin exp_w[ndata] = msk(w, dl); ndata++; end
    end
    nexp = ndata + 6;
    for (int i = ndata; i < nexp; i++)
      exp_w[i] = (rep && ndata >= 2) ? exp_w[ndata - 2 + (i - ndata) % 2] : 32'd0;
    cap_on = 1;
    cmd_en = 1'b1;
    @(negedge clk);
    cmd_en = 1'b0;
    chk(tx_enabled == 1'b1, "R1", "enabled after cmd_en", tx_enabled, 1);
    if (!m) sl_run = 1;
    for (int k = 0; k < nwr; k++) begin
      while (!tx_ready) @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = (32'h9E37_79B9 * (k + 1)) ^ {24'd0, len, 5'd3};
      @(negedge clk);
      wr_valid = 1'b0;
      if (junk && !tx_ready) begin
        wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_valid = 1'b0;
      end
    end
    feed_done = 1;
    pp = m ? 2 * HALF : 2 * SHALF;
    repeat (5 * 2 * sw * pp) @(negedge clk);
    cap_on = 0;
    if (m) chk(per == 2 * HALF, "R3", "bit clock period", per, 2 * HALF);
    cmd_dis = 1'b1; cmd_en = 1'b1;
    @(negedge clk);
    cmd_dis = 1'b0; cmd_en = 1'b0;
    sl_run = 0;
    repeat (3) @(negedge clk);
    chk(tx_enabled == 1'b0, "R1", "disabled wins", tx_enabled, 0);
    chk(bclk_o == 1'b0 && sd_o == 1'b0 && ws_o == 1'b0, "R1", "idle lines",
        {bclk_o, ws_o, sd_o}, 0);
    // decode
    nwd = 0; prev_start = -1; nslot = 0;
    off = lj ? 0 : 1;
    for (int i = 0; i < nb; i++) begin
      if (i == 0 || bws[i] != bws[i-1]) begin
        if (prev_start >= 0 && nslot < 3) begin
          chk(i - prev_start == sw, "R4", "slot width", i - prev_start, sw);
          nslot++;
        end
        prev_start = i;
        if (i + off + dl <= nb && nwd < 256) begin
          acc = 0;
          for (int j = 0; j < dl; j++) acc = (acc << 1) | 32'(bsd[i + off + j]);
          dw[nwd] = acc; dch[nwd] = bws[i]; nwd++;
        end
      end
    end
    chk(nwd >= ndata + 2, "R8", "words decoded incl. fillers", nwd, ndata + 2);
    for (int i = 0; i < nexp && i < nwd; i++) begin
      if (i < ndata) chk(dw[i] == exp_w[i], tag, "sample word", dw[i], exp_w[i]);
      else chk(dw[i] == exp_w[i], "R8", "filler word", dw[i], exp_w[i]);
      chk(dch[i] == bit'(i % 2), "R3", "slot channel", dch[i], i % 2);
    end
    chk(first_ur == (comp ? 2'b11 : 2'b01), "R8", "first underrun channel", first_ur, comp ? 3 : 1);
    chk(early == 0, "R8", "no underrun while fed", early, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_enabled == 1'b0 && tx_ready == 1'b0, "R1", "reset status", {tx_enabled, tx_ready}, 0);
    chk(bclk_o == 1'b0 && ws_o == 1'b0 && sd_o == 1'b0 && urun_ch == 2'b00, "R1", "reset lines",
        {bclk_o, ws_o, sd_o, urun_ch}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    //   m  lj len   s24 mono rep nwr junk pre
    run(1, 0, 3'd0, 0, 0, 1, 6, 0, 0, "R5");
    run(1, 1, 3'd1, 0, 0, 0, 6, 1, 0, "R2");
    run(1, 0, 3'd1, 1, 0, 1, 4, 0, 0, "R4");
    run(1, 1, 3'd2, 1, 0, 0, 4, 0, 0, "R4");
    run(1, 0, 3'd3, 0, 0, 1, 4, 0, 0, "R4");
    run(1, 1, 3'd4, 0, 1, 1, 4, 0, 0, "R6");
    run(1, 0, 3'd5, 0, 0, 1, 4, 0, 0, "R7");
    run(1, 1, 3'd7, 0, 0, 0, 4, 0, 0, "R7");
    run(1, 0, 3'd6, 0, 0, 0, 6, 0, 0, "R5");
    run(0, 0, 3'd4, 0, 0, 0, 6, 0, 0, "R9");
    run(0, 1, 3'd6, 0, 1, 1, 4, 0, 0, "R9");
    run(1, 0, 3'd4, 0, 0, 0, 0, 0, 1, "R2");
    finish_up();
  end
endmodule